// File: doc/BRIEF.md
# Completion Header Generator with Byte Tracking

This block answers non-posted requests with completion headers. A request handshake delivers the fields kept from the original request: requester ID, tag, traffic class, attribute bits, the low twelve bits of the address and the total byte count. Along with them come the completer's own ID, the completion status and a chunk-size code that sets how many bytes a single completion may carry. The block then emits one or more three-dword completion headers on a valid/ready stream. Each header is marked as either carrying data or carrying status only. The data payload itself travels on a separate path that this block does not model.

For a successful memory read the block splits the transfer at chunk boundaries. After each accepted header it updates the running start address and the remaining byte count. Every header carries the byte count still outstanding, including its own share, and the low seven bits of its first byte's address. IO and configuration completions always consist of a single header. A failed request of any kind yields one status-only header. A posted request is taken from the input and produces nothing.

The controller is a three-state machine:
- `S_IDLE` waits for a request.
- `S_SEND_DATA` presents headers that carry data.
- `S_SEND_STAT` presents the single header that carries status only.

Its transitions are:
- T_DROP: `S_IDLE` to `S_IDLE` when a posted request is accepted.
- T_START: `S_IDLE` to `S_SEND_DATA` for a successful read.
- T_ACK_WR: `S_IDLE` to `S_SEND_STAT` for a successful IO or configuration write.
- T_REJECT: `S_IDLE` to `S_SEND_STAT` for any status other than success.
- T_NEXT: `S_SEND_DATA` to `S_SEND_DATA` when a non-final header is accepted.
- T_DONE: `S_SEND_DATA` to `S_IDLE` when the final header is accepted.
- T_STAT_DONE: `S_SEND_STAT` to `S_IDLE` when the header is accepted.

Top module: `cplgen_top`

## Requirements
- R1: The traffic class, attribute bits, requester ID and tag of the request appear unchanged in every header generated for it, and so does the completer ID that was sampled when the request was accepted.
- R2: The header layout is fixed. hdr_data[95:64] is dword 0: format [31:29] is 010 for a header with data and 000 for status only, type [28:24] is 01010, traffic class sits in [22:20], attributes in [13:12] and length in [9:0]. hdr_data[63:32] is dword 1: completer ID [31:16], status [15:13], byte count [11:0]. hdr_data[31:0] is dword 2: requester ID [31:16], tag [15:8], lower address [6:0]. All other bits are 0.
- R3: Status codes are success=000, unsupported=001, retry=010 and abort=100. Any status other than 000 produces exactly one status-only header with length 0. Its byte count is the full request byte count for a memory read and 4 otherwise. Its lower address is the request address bits [6:0] for a memory read and 0 otherwise.
- R4: For a successful memory read, the chunk size is 64 << chunk_sel bytes. Each header covers min(remaining, chunk − (address mod chunk)) bytes. Its byte count field holds the bytes still outstanding, including its own, and the value 4096 is encoded as 0.
- R5: The lower address field is bits [6:0] of the header's first byte address. Every header after the first starts on a 64-byte-aligned address.
- R6: The length field of a memory-read header with data is ceil((address[1:0] + bytes) / 4) dwords.
- R7: The request kind is encoded as 00 memory read, 01 IO/configuration read, 10 IO/configuration write and 11 posted. A successful kind 01 yields one header with data, length 1, byte count 4 and lower address 0. A successful kind 10 yields one status-only header with length 0, byte count 4 and lower address 0.
- R8: A request of kind 11 is accepted and no header is produced for it.
- R9: After reset no header is valid and req_ready is 1. req_ready is 1 only when no header is pending. hdr_last is 1 exactly on the final header of a request. A header held under backpressure keeps its data and its last flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request fields are valid |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 2 | Request kind (see R7) |
| req_id | input | 16 | Requester ID |
| req_tag | input | 8 | Request tag |
| req_tc | input | 3 | Traffic class |
| req_attr | input | 2 | Attribute bits |
| req_addr | input | 12 | Request address bits [11:0] |
| req_bytes | input | 13 | Total bytes requested, 1 to 4096 |
| cpl_id | input | 16 | Completer ID |
| cpl_status | input | 3 | Completion status |
| chunk_sel | input | CHUNK_SEL_W | Chunk size code, 64 << code bytes |
| hdr_valid | output | 1 | Header is valid |
| hdr_ready | input | 1 | Sink accepts the header |
| hdr_data | output | 96 | Header, dword 0 in the top bits |
| hdr_last | output | 1 | Final header of this request |

## Verification
The bench drives reads whose start sits just below a chunk boundary. A design that rounds the first share the wrong way would show this as a wrong byte count or a wrong dword length in the first header. It also drives a full 4096-byte read, which catches a design that fails to encode the count as 0 or that leaves the running address unaligned. Error statuses are sent on both memory and IO requests: a wrong design would emit data headers, emit more than one header, or report the memory count for IO. A posted request must produce no header at all. Random backpressure exposes a header that changes while it is held.

// File: rtl/cplgen_pkg.sv
package cplgen_pkg;

    localparam int RID_W    = 16;
    localparam int TAG_W    = 8;
    localparam int TC_W     = 3;
    localparam int ATTR_W   = 2;
    localparam int STAT_W   = 3;
    localparam int ADDR_W   = 12;
    localparam int BCNT_W   = 13;
    localparam int LEN_W    = 10;
    localparam int BCF_W    = 12;
    localparam int LA_W     = 7;
    localparam int HDR_W    = 96;

    localparam logic [STAT_W-1:0] STAT_SC  = 3'b000;
    localparam logic [STAT_W-1:0] STAT_UR  = 3'b001;
    localparam logic [STAT_W-1:0] STAT_CRS = 3'b010;
    localparam logic [STAT_W-1:0] STAT_CA  = 3'b100;

    localparam logic [4:0] CPL_TYPE    = 5'b01010;
    localparam logic [2:0] FMT_DATA    = 3'b010;
    localparam logic [2:0] FMT_NODATA  = 3'b000;

    typedef enum logic [1:0] {
        K_MEM_RD = 2'b00,
        K_NP_RD  = 2'b01,
        K_NP_WR  = 2'b10,
        K_POSTED = 2'b11
    } req_kind_e;

    typedef enum logic [1:0] {
        S_IDLE      = 2'b00,
        S_SEND_DATA = 2'b01,
        S_SEND_STAT = 2'b10
    } fsm_e;

    typedef struct packed {
        logic [RID_W-1:0]  rid;
        logic [TAG_W-1:0]  tag;
        logic [TC_W-1:0]   tc;
        logic [ATTR_W-1:0] attr;
        logic [RID_W-1:0]  cid;
        logic [STAT_W-1:0] status;
        req_kind_e         kind;
    } req_info_t;

endpackage

// File: rtl/cplgen_capture.sv
module cplgen_capture
    import cplgen_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  req_info_t info_in,
    output req_info_t info_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            info_q <= '0;
        end else if (load) begin
            info_q <= info_in;
        end
    end

endmodule

// File: rtl/cplgen_tracker.sv
module cplgen_tracker #(
    parameter int SEL_W     = 2,
    parameter int BASE_LOG2 = 6,
    parameter int ADDR_W    = 12,
    parameter int BCNT_W    = 13,
    parameter int DW_W      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [BCNT_W-1:0] bcnt_in,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic              advance,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [BCNT_W-1:0] remaining,
    output logic [BCNT_W-1:0] seg_bytes,
    output logic [DW_W-1:0]   seg_dw,
    output logic              seg_last
);

    localparam int SPAN_W = BCNT_W + 1;

    logic [SEL_W-1:0]  sel_q;
    logic [BCNT_W-1:0] chunk;
    logic [BCNT_W-1:0] offset;
    logic [BCNT_W-1:0] room;
    logic [SPAN_W-1:0] span;

    always_comb begin
        chunk     = BCNT_W'(1) << (BASE_LOG2 + int'(sel_q));
        offset    = BCNT_W'(cur_addr) & (chunk - BCNT_W'(1));
        room      = chunk - offset;
        seg_last  = (remaining <= room);
        seg_bytes = seg_last ? remaining : room;
        span      = SPAN_W'(cur_addr[1:0]) + SPAN_W'(seg_bytes) + SPAN_W'(3);
        seg_dw    = DW_W'(span >> 2);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            remaining <= '0;
            sel_q     <= '0;
        end else if (load) begin
            cur_addr  <= addr_in;
            remaining <= bcnt_in;
            sel_q     <= sel_in;
        end else if (advance) begin
            cur_addr  <= cur_addr + seg_bytes[ADDR_W-1:0];
            remaining <= remaining - seg_bytes;
        end
    end

    // R4: a non-final step leaves fewer, but still some, bytes outstanding
    p_rem_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && !seg_last) |=> (remaining < $past(remaining)) && (remaining != '0));

    // R5: every later completion starts on an aligned address
    p_next_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && !seg_last) |=> (cur_addr[BASE_LOG2-1:0] == '0));

endmodule

// File: rtl/cplgen_pack.sv
module cplgen_pack
    import cplgen_pkg::*;
(
    input  req_info_t        info,
    input  logic             has_data,
    input  logic [LEN_W-1:0] len,
    input  logic [BCF_W-1:0] bcnt,
    input  logic [LA_W-1:0]  low_addr,
    output logic [HDR_W-1:0] hdr
);

    logic [31:0] dw0;
    logic [31:0] dw1;
    logic [31:0] dw2;

    always_comb begin
        dw0 = '0;
        dw0[31:29] = has_data ? FMT_DATA : FMT_NODATA;
        dw0[28:24] = CPL_TYPE;
        dw0[22:20] = info.tc;
        dw0[13:12] = info.attr;
        dw0[9:0]   = len;

        dw1 = '0;
        dw1[31:16] = info.cid;
        dw1[15:13] = info.status;
        dw1[11:0]  = bcnt;

        dw2 = '0;
        dw2[31:16] = info.rid;
        dw2[15:8]  = info.tag;
        dw2[6:0]   = low_addr;

        hdr = {dw0, dw1, dw2};
    end

endmodule

// File: rtl/cplgen_top.sv
module cplgen_top
    import cplgen_pkg::*;
#(
    parameter int CHUNK_SEL_W     = 2,
    parameter int CHUNK_BASE_LOG2 = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [1:0]             req_kind,
    input  logic [RID_W-1:0]       req_id,
    input  logic [TAG_W-1:0]       req_tag,
    input  logic [TC_W-1:0]        req_tc,
    input  logic [ATTR_W-1:0]      req_attr,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [BCNT_W-1:0]      req_bytes,
    input  logic [RID_W-1:0]       cpl_id,
    input  logic [STAT_W-1:0]      cpl_status,
    input  logic [CHUNK_SEL_W-1:0] chunk_sel,
    output logic                   hdr_valid,
    input  logic                   hdr_ready,
    output logic [HDR_W-1:0]       hdr_data,
    output logic                   hdr_last
);

    fsm_e       state_q;
    fsm_e       state_d;
    req_info_t  info_in;
    req_info_t  info_q;
    logic       accept;
    logic       load;
    logic       fire;
    logic       is_mem;
    logic       advance;

    logic [ADDR_W-1:0] cur_addr;
    logic [BCNT_W-1:0] remaining;
    logic [BCNT_W-1:0] seg_bytes;
    logic [LEN_W-1:0]  seg_dw;
    logic              seg_last;

    logic              f_data;
    logic [LEN_W-1:0]  f_len;
    logic [BCF_W-1:0]  f_bcnt;
    logic [LA_W-1:0]   f_la;

    always_comb begin
        info_in.rid    = req_id;
        info_in.tag    = req_tag;
        info_in.tc     = req_tc;
        info_in.attr   = req_attr;
        info_in.cid    = cpl_id;
        info_in.status = cpl_status;
        info_in.kind   = req_kind_e'(req_kind);
    end

    assign accept  = req_valid && req_ready;
    assign load    = accept && (req_kind_e'(req_kind) != K_POSTED);
    assign fire    = hdr_valid && hdr_ready;
    assign is_mem  = (info_q.kind == K_MEM_RD);
    assign advance = fire && is_mem && (state_q == S_SEND_DATA);

    cplgen_capture u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .info_in (info_in),
        .info_q  (info_q)
    );

    cplgen_tracker #(
        .SEL_W     (CHUNK_SEL_W),
        .BASE_LOG2 (CHUNK_BASE_LOG2),
        .ADDR_W    (ADDR_W),
        .BCNT_W    (BCNT_W),
        .DW_W      (LEN_W)
    ) u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .addr_in   (req_addr),
        .bcnt_in   (req_bytes),
        .sel_in    (chunk_sel),
        .advance   (advance),
        .cur_addr  (cur_addr),
        .remaining (remaining),
        .seg_bytes (seg_bytes),
        .seg_dw    (seg_dw),
        .seg_last  (seg_last)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    if (req_kind_e'(req_kind) == K_POSTED) begin
                        state_d = S_IDLE;                       // T_DROP
                    end else if (cpl_status != STAT_SC) begin
                        state_d = S_SEND_STAT;                  // T_REJECT
                    end else if (req_kind_e'(req_kind) == K_NP_WR) begin
                        state_d = S_SEND_STAT;                  // T_ACK_WR
                    end else begin
                        state_d = S_SEND_DATA;                  // T_START
                    end
                end
            end
            S_SEND_DATA: begin
                if (hdr_ready) begin
                    state_d = (!is_mem || seg_last) ? S_IDLE    // T_DONE
                                                    : S_SEND_DATA; // T_NEXT
                end
            end
            S_SEND_STAT: begin
                if (hdr_ready) begin
                    state_d = S_IDLE;                           // T_STAT_DONE
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output process
    always_comb begin
        req_ready = 1'b0;
        hdr_valid = 1'b0;
        hdr_last  = 1'b0;
        f_data    = 1'b0;
        f_len     = '0;
        f_bcnt    = is_mem ? remaining[BCF_W-1:0] : BCF_W'(4);
        f_la      = is_mem ? cur_addr[LA_W-1:0] : '0;
        unique case (state_q)
            S_IDLE: begin
                req_ready = 1'b1;
            end
            S_SEND_DATA: begin
                hdr_valid = 1'b1;
                hdr_last  = !is_mem || seg_last;
                f_data    = 1'b1;
                f_len     = is_mem ? seg_dw : LEN_W'(1);
            end
            S_SEND_STAT: begin
                hdr_valid = 1'b1;
                hdr_last  = 1'b1;
            end
            default: begin
                req_ready = 1'b0;
            end
        endcase
    end

    cplgen_pack u_pack (
        .info     (info_q),
        .has_data (f_data),
        .len      (f_len),
        .bcnt     (f_bcnt),
        .low_addr (f_la),
        .hdr      (hdr_data)
    );

    // R9: a header under backpressure does not move
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !hdr_ready) |=> hdr_valid && $stable(hdr_data) && $stable(hdr_last));

    // R3: a status-only header ends its request at once
    p_stat_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SEND_STAT && hdr_ready) |=> req_ready);

    // R3: a header without data carries length 0
    p_nodata_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !hdr_data[94]) |-> (hdr_data[73:64] == '0));

    // R8: a posted request never opens a header
    p_posted_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_kind == 2'b11) |=> !hdr_valid);

endmodule

// File: tb/cplgen_top_tb_top.sv
module cplgen_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = '0;
    logic [15:0] req_id = '0;
    logic [7:0]  req_tag = '0;
    logic [2:0]  req_tc = '0;
    logic [1:0]  req_attr = '0;
    logic [11:0] req_addr = '0;
    logic [12:0] req_bytes = '0;
    logic [15:0] cpl_id = '0;
    logic [2:0]  cpl_status = '0;
    logic [1:0]  chunk_sel = '0;
    logic        hdr_valid;
    logic        hdr_ready = 1'b0;
    logic [95:0] hdr_data;
    logic        hdr_last;

    int total = 0;
    int bad   = 0;

    logic [96:0] exp_q[$];
    string       tag_q[$];

    logic [2:0]  t_tc;
    logic [1:0]  t_attr;
    logic [15:0] t_rid;
    logic [7:0]  t_tag;
    logic [15:0] t_cid;
    logic [2:0]  t_st;

    always #10 clk = ~clk;

    cplgen_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_kind   (req_kind),
        .req_id     (req_id),
        .req_tag    (req_tag),
        .req_tc     (req_tc),
        .req_attr   (req_attr),
        .req_addr   (req_addr),
        .req_bytes  (req_bytes),
        .cpl_id     (cpl_id),
        .cpl_status (cpl_status),
        .chunk_sel  (chunk_sel),
        .hdr_valid  (hdr_valid),
        .hdr_ready  (hdr_ready),
        .hdr_data   (hdr_data),
        .hdr_last   (hdr_last)
    );

    task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    task automatic push_hdr(input bit data, input int len, input int bc, input int la, input bit last, input string tg);
        logic [96:0] e;
        logic [9:0]  l10;
        logic [11:0] b12;
        logic [6:0]  a7;
        l10 = 10'(len);
        b12 = 12'(bc);
        a7  = 7'(la);
        e = {last,
             (data ? 3'b010 : 3'b000), 5'b01010, 1'b0, t_tc, 6'b0, t_attr, 2'b0, l10,
             t_cid, t_st, 1'b0, b12,
             t_rid, t_tag, 1'b0, a7};
        exp_q.push_back(e);
        tag_q.push_back(tg);
    endtask

    task automatic do_req(input int kind, input int addr, input int bytes, input int sel, input int st,
                          input int tc, input int attr, input int rid, input int tg_v, input int cid,
                          input string tg);
        t_tc = 3'(tc); t_attr = 2'(attr); t_rid = 16'(rid);
        t_tag = 8'(tg_v); t_cid = 16'(cid); t_st = 3'(st);
        if (kind == 3) begin
        end else if (st != 0) begin
            push_hdr(0, 0, (kind == 0) ? bytes : 4, (kind == 0) ? (addr % 128) : 0, 1, tg);
        end else if (kind == 1) begin
            push_hdr(1, 1, 4, 0, 1, tg);
        end else if (kind == 2) begin
            push_hdr(0, 0, 4, 0, 1, tg);
        end else begin
            int a;
            int rem;
            int chunk;
            a = addr; rem = bytes; chunk = 64 << sel;
            while (rem > 0) begin
                int room;
                int b;
                room = chunk - (a % chunk);
                b = (rem < room) ? rem : room;
                push_hdr(1, ((a % 4) + b + 3) / 4, rem % 4096, a % 128, b == rem, tg);
                a = a + b;
                rem = rem - b;
            end
        end
        @(negedge clk);
        req_kind = 2'(kind); req_addr = 12'(addr); req_bytes = 13'(bytes);
        chunk_sel = 2'(sel); cpl_status = 3'(st); req_tc = 3'(tc); req_attr = 2'(attr);
        req_id = 16'(rid); req_tag = 8'(tg_v); cpl_id = 16'(cid);
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    logic [7:0] lfsr = 8'h5a;
    always @(posedge clk) begin
        #5;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        hdr_ready = lfsr[0] | lfsr[2];
    end

    logic        held = 1'b0;
    logic [96:0] held_v;

    always @(negedge clk) begin
        if (rst_n && hdr_valid) begin
            if (held) begin
                chk({hdr_last, hdr_data} == held_v, "R9 held header changed", 128'({hdr_last, hdr_data}), 128'(held_v));
            end
            if (hdr_ready) begin
                held = 1'b0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected header", 128'(hdr_data), 128'(0));
                end else begin
                    logic [96:0] e;
                    string tg;
                    e  = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    chk({hdr_data[86:84], hdr_data[77:76], hdr_data[63:48], hdr_data[31:8]} ==
                        {e[86:84], e[77:76], e[63:48], e[31:8]}, {tg, " R1 copied fields"},
                        128'(hdr_data), 128'(e[95:0]));
                    chk({hdr_data[95:87], hdr_data[83:78], hdr_data[75:74], hdr_data[44], hdr_data[7]} ==
                        {e[95:87], e[83:78], e[75:74], e[44], e[7]}, {tg, " R2 format and type"},
                        128'(hdr_data[95:64]), 128'(e[95:64]));
                    chk(hdr_data[47:45] == e[47:45], {tg, " R3 status"}, 128'(hdr_data[47:45]), 128'(e[47:45]));
                    chk(hdr_data[43:32] == e[43:32], {tg, " R4 byte count"}, 128'(hdr_data[43:32]), 128'(e[43:32]));
                    chk(hdr_data[6:0] == e[6:0], {tg, " R5 lower address"}, 128'(hdr_data[6:0]), 128'(e[6:0]));
                    chk(hdr_data[73:64] == e[73:64], {tg, " R6 length"}, 128'(hdr_data[73:64]), 128'(e[73:64]));
                    chk(hdr_last == e[96], {tg, " R9 last flag"}, 128'(hdr_last), 128'(e[96]));
                end
            end else begin
                held   = 1'b1;
                held_v = {hdr_last, hdr_data};
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R9 watchdog expired", 128'(exp_q.size()), 128'(0));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(req_ready === 1'b1, "R9 reset req_ready", 128'(req_ready), 128'(1));
        chk(hdr_valid === 1'b0, "R9 reset hdr_valid", 128'(hdr_valid), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);

        do_req(0, 12'h080, 128, 0, 0, 5, 2, 16'h1234, 8'h11, 16'hbeef, "R4 aligned split");
        do_req(0, 12'h03d, 10, 0, 0, 1, 1, 16'h0a0b, 8'h22, 16'h0102, "R5 unaligned start");
        do_req(0, 12'h000, 4096, 3, 0, 7, 3, 16'hffff, 8'hff, 16'h8001, "R4 full page");
        do_req(0, 12'h105, 3, 1, 0, 2, 0, 16'h0042, 8'h33, 16'h0077, "R6 single small");
        do_req(0, 12'h0fe, 300, 1, 0, 3, 2, 16'h5555, 8'h44, 16'haaaa, "R6 odd span");
        do_req(1, 12'h123, 4, 0, 0, 0, 0, 16'h0101, 8'h55, 16'h0202, "R7 io read");
        do_req(2, 12'h044, 4, 0, 0, 0, 0, 16'h0303, 8'h66, 16'h0404, "R7 config write");
        do_req(0, 12'h2c9, 200, 0, 1, 4, 1, 16'h0606, 8'h77, 16'h0808, "R3 memory unsupported");
        do_req(1, 12'h010, 4, 0, 2, 0, 0, 16'h0909, 8'h88, 16'h0a0a, "R3 config retry");
        do_req(0, 12'h400, 64, 2, 4, 6, 3, 16'h0b0b, 8'h99, 16'h0c0c, "R3 memory abort");
        drain();

        do_req(3, 12'h100, 64, 0, 0, 1, 1, 16'h0d0d, 8'haa, 16'h0e0e, "R8 posted");
        for (int i = 0; i < 6; i++) begin
            chk(hdr_valid === 1'b0, "R8 posted raised a header", 128'(hdr_valid), 128'(0));
            @(negedge clk);
        end
        do_req(0, 12'h7f8, 72, 0, 0, 5, 0, 16'h0f0f, 8'hbb, 16'h1010, "R1 after posted");
        do_req(2, 12'h000, 4, 0, 0, 0, 0, 16'h2222, 8'hcc, 16'h3333, "R7 io write");
        drain();

        chk(exp_q.size() == 0, "R9 headers left outstanding", 128'(exp_q.size()), 128'(0));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule